// File: doc/BRIEF.md
# Segment Descriptor Fetch Unit

This block turns a 16-bit segment selector into a decoded segment descriptor. On a request it masks the selector down to a table offset and picks the global or the local descriptor table from one selector bit. It checks the offset against that table's limit, then reads the 8-byte descriptor as two 32-bit words over a simple one-read-at-a-time memory port. The result is returned as base address, effective limit (expanded by the granularity bit), type, privilege level, present bit and default-size bit, with a one-cycle completion or fault pulse.

The global table's base and limit are written through a small configuration port. The local table is installed by a second request kind. That request always fetches from the global table, then stores the fetched descriptor's base and effective limit as the local table and keeps the selector for readback. All table registers clear on reset, so every lookup faults until software configures the tables.

Top module: `seg_desc_fetch`

## Requirements
- R1: The table offset is the selector with its low three bits forced to zero. Selector bit 2 set picks the local table and clear picks the global table, and the first read address is the picked table base plus that offset.
- R2: When the offset is greater than or equal to the picked table's limit, `fault` pulses in the cycle after acceptance and no memory read is issued.
- R3: A fetch issues exactly two reads, the second at the first address plus 4. Only one read is outstanding at a time, and the second read is issued only after `mem_rd_valid` has returned the first word.
- R4: `desc_base` is {second word[31:24], second word[7:0], first word[31:16]}.
- R5: The raw limit is {second word[19:16], first word[15:0]}. When second word bit 23 is set, `desc_limit` is the raw limit shifted left 12 with the low 12 bits set to one; otherwise it is the raw limit zero-extended.
- R6: `desc_type` is second word[12:8], `desc_dpl` is second word[14:13], `desc_present` is second word bit 15 and `desc_big` is second word bit 22.
- R7: A request with `req_load_local`=1 reads from the global table whatever selector bit 2 holds. On completion it sets the local table base and limit to the fetched descriptor's base and effective limit and `ldt_sel` to the request selector, all visible in the `done` cycle.
- R8: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle `done` rises. `done` and `fault` are single-cycle pulses that are never high together, and `req_valid` while busy has no effect.
- R9: After reset all table registers and decoded outputs are zero, so any lookup faults before configuration.
- R10: Decoded outputs clear to zero in the cycle after a request is accepted and keep their values after `done` until the next acceptance.
- R11: A global-table configuration write in the same cycle as a request acceptance takes effect from the next cycle. The accepted request is bounds-checked and addressed with the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_sel | input | 16 | Segment selector |
| req_load_local | input | 1 | 1: install local table from global entry; 0: plain lookup |
| cfg_we | input | 1 | Global table register write |
| cfg_base | input | 32 | Global table base to write |
| cfg_limit | input | 32 | Global table limit to write |
| mem_rd_req | output | 1 | One-cycle read issue |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data return |
| mem_rd_data | input | 32 | Read data word |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Fetch completed pulse |
| fault | output | 1 | Out-of-bounds pulse |
| desc_base | output | 32 | Decoded segment base |
| desc_limit | output | 32 | Decoded effective limit |
| desc_type | output | 5 | Decoded type field |
| desc_dpl | output | 2 | Decoded privilege level |
| desc_present | output | 1 | Decoded present bit |
| desc_big | output | 1 | Decoded default-size bit |
| ldt_base | output | 32 | Current local table base |
| ldt_limit | output | 32 | Current local table limit |
| ldt_sel | output | 16 | Selector last used to install the local table |

## Verification
A global-table write and a request acceptance can land on the same clock edge. The bench drives `cfg_we` together with `req_valid` both ways. It raises the limit from zero so a lookup that would pass afterwards must still fault, and it drops a large limit to zero so the accepted lookup must still complete. It also moves the base under an in-bounds request and expects the read address from the old base. The register model in the bench applies the write only after forming its expectation, so any mismatch in fault, read address or decoded fields points at the wrong ordering.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;

   localparam int unsigned DESC_WORD_W = 32;
   localparam int unsigned RAW_LIMIT_W = 20;
   localparam int unsigned TYPE_W      = 5;
   localparam int unsigned DPL_W       = 2;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_ISSUE_LO = 3'd1,
      ST_WAIT_LO  = 3'd2,
      ST_ISSUE_HI = 3'd3,
      ST_WAIT_HI  = 3'd4
   } fetch_state_e;

   typedef struct packed {
      logic [DESC_WORD_W-1:0] base;
      logic [TYPE_W-1:0]      kind;
      logic [DPL_W-1:0]       dpl;
      logic                   present;
      logic                   big;
   } desc_fields_t;

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
   import seg_desc_pkg::*;
#(
   parameter int unsigned GRAN_SHIFT = 12,
   localparam int unsigned LIM_W     = RAW_LIMIT_W + GRAN_SHIFT
) (
   input  logic [DESC_WORD_W-1:0] word_lo,
   input  logic [DESC_WORD_W-1:0] word_hi,
   output desc_fields_t           fields,
   output logic [LIM_W-1:0]       eff_limit
);

   logic [RAW_LIMIT_W-1:0] raw_limit;
   logic                   gran;
   logic                   unused_hi;

   assign raw_limit = {word_hi[19:16], word_lo[15:0]};
   assign gran      = word_hi[23];
   assign unused_hi = ^word_hi[21:20];

   assign fields.base    = {word_hi[31:24], word_hi[7:0], word_lo[31:16]};
   assign fields.kind    = word_hi[12:8];
   assign fields.dpl     = word_hi[14:13];
   assign fields.present = word_hi[15];
   assign fields.big     = word_hi[22];

   generate
      if (GRAN_SHIFT == 0) begin : g_no_gran
         assign eff_limit = raw_limit;
      end else begin : g_gran
         assign eff_limit = gran ? {raw_limit, {GRAN_SHIFT{1'b1}}}
                                 : {{GRAN_SHIFT{1'b0}}, raw_limit};
      end
   endgenerate

endmodule

// File: rtl/seg_table_regs.sv
module seg_table_regs
   import seg_desc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LIM_W  = 32,
   parameter int unsigned SEL_W  = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [ADDR_W-1:0]      cfg_base,
   input  logic [LIM_W-1:0]       cfg_limit,
   input  logic                   inst_we,
   input  logic [DESC_WORD_W-1:0] inst_base,
   input  logic [LIM_W-1:0]       inst_limit,
   input  logic [SEL_W-1:0]       inst_sel,
   input  logic                   use_local,
   output logic [ADDR_W-1:0]      pick_base,
   output logic [LIM_W-1:0]       pick_limit,
   output logic [ADDR_W-1:0]      loc_base,
   output logic [LIM_W-1:0]       loc_limit,
   output logic [SEL_W-1:0]       loc_sel
);

   logic [ADDR_W-1:0] glb_base_q;
   logic [LIM_W-1:0]  glb_limit_q;
   logic [ADDR_W-1:0] loc_base_q;
   logic [LIM_W-1:0]  loc_limit_q;
   logic [SEL_W-1:0]  loc_sel_q;
   logic [ADDR_W-1:0] inst_base_ext;

   generate
      if (ADDR_W == DESC_WORD_W) begin : g_same_w
         assign inst_base_ext = inst_base;
      end else begin : g_wide
         assign inst_base_ext = {{(ADDR_W-DESC_WORD_W){1'b0}}, inst_base};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glb_base_q  <= '0;
         glb_limit_q <= '0;
      end else if (cfg_we) begin
         glb_base_q  <= cfg_base;
         glb_limit_q <= cfg_limit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_base_q  <= '0;
         loc_limit_q <= '0;
         loc_sel_q   <= '0;
      end else if (inst_we) begin
         loc_base_q  <= inst_base_ext;
         loc_limit_q <= inst_limit;
         loc_sel_q   <= inst_sel;
      end
   end

   assign pick_base  = use_local ? loc_base_q  : glb_base_q;
   assign pick_limit = use_local ? loc_limit_q : glb_limit_q;
   assign loc_base   = loc_base_q;
   assign loc_limit  = loc_limit_q;
   assign loc_sel    = loc_sel_q;

endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
   import seg_desc_pkg::*;
#(
   parameter int unsigned SEL_W   = 16,
   parameter int unsigned TI_BIT  = 2,
   parameter int unsigned IDX_LSB = 3,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned LIM_W   = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [SEL_W-1:0]       req_sel,
   input  logic                   req_load_local,
   input  logic [ADDR_W-1:0]      pick_base,
   input  logic [LIM_W-1:0]       pick_limit,
   output logic                   use_local,
   output logic                   mem_rd_req,
   output logic [ADDR_W-1:0]      mem_rd_addr,
   input  logic                   mem_rd_valid,
   input  logic [DESC_WORD_W-1:0] mem_rd_data,
   output logic [DESC_WORD_W-1:0] word_lo,
   input  desc_fields_t           dec_fields,
   input  logic [LIM_W-1:0]       dec_limit,
   output logic                   inst_we,
   output logic [SEL_W-1:0]       inst_sel,
   output logic                   busy,
   output logic                   done,
   output logic                   fault,
   output desc_fields_t           out_fields,
   output logic [LIM_W-1:0]       out_limit
);

   localparam int unsigned WORD_BYTES = DESC_WORD_W / 8;

   fetch_state_e           state_q, state_d;
   logic [ADDR_W-1:0]      addr_q;
   logic                   op_q;
   logic [SEL_W-1:0]       sel_q;
   logic [DESC_WORD_W-1:0] lo_q;
   logic                   done_q, fault_q;
   desc_fields_t           fields_q;
   logic [LIM_W-1:0]       limit_q;

   logic                   accept;
   logic                   out_of_range;
   logic                   last_word;
   logic [SEL_W-1:0]       ofs;

   assign ofs          = {req_sel[SEL_W-1:IDX_LSB], {IDX_LSB{1'b0}}};
   assign use_local    = req_sel[TI_BIT] & ~req_load_local;
   assign accept       = (state_q == ST_IDLE) && req_valid;
   assign out_of_range = LIM_W'(ofs) >= pick_limit;
   assign last_word    = (state_q == ST_WAIT_HI) && mem_rd_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:     if (accept && !out_of_range) state_d = ST_ISSUE_LO;
         ST_ISSUE_LO: state_d = ST_WAIT_LO;
         ST_WAIT_LO:  if (mem_rd_valid) state_d = ST_ISSUE_HI;
         ST_ISSUE_HI: state_d = ST_WAIT_HI;
         ST_WAIT_HI:  if (mem_rd_valid) state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         op_q    <= 1'b0;
         sel_q   <= '0;
         lo_q    <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= last_word;
         fault_q <= accept && out_of_range;
         if (accept) begin
            addr_q <= pick_base + ADDR_W'(ofs);
            op_q   <= req_load_local;
            sel_q  <= req_sel;
         end
         if ((state_q == ST_WAIT_LO) && mem_rd_valid) begin
            lo_q <= mem_rd_data;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fields_q <= '0;
         limit_q  <= '0;
      end else if (accept) begin
         fields_q <= '0;
         limit_q  <= '0;
      end else if (last_word) begin
         fields_q <= dec_fields;
         limit_q  <= dec_limit;
      end
   end

   assign mem_rd_req  = (state_q == ST_ISSUE_LO) || (state_q == ST_ISSUE_HI);
   assign mem_rd_addr = (state_q == ST_ISSUE_HI) ? addr_q + ADDR_W'(WORD_BYTES) : addr_q;
   assign word_lo     = lo_q;
   assign inst_we     = last_word && op_q;
   assign inst_sel    = sel_q;
   assign busy        = (state_q != ST_IDLE);
   assign done        = done_q;
   assign fault       = fault_q;
   assign out_fields  = fields_q;
   assign out_limit   = limit_q;

endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
   import seg_desc_pkg::*;
#(
   parameter int unsigned SEL_W      = 16,
   parameter int unsigned TI_BIT     = 2,
   parameter int unsigned IDX_LSB    = 3,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned GRAN_SHIFT = 12,
   localparam int unsigned LIM_W     = RAW_LIMIT_W + GRAN_SHIFT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [SEL_W-1:0]       req_sel,
   input  logic                   req_load_local,
   input  logic                   cfg_we,
   input  logic [ADDR_W-1:0]      cfg_base,
   input  logic [LIM_W-1:0]       cfg_limit,
   output logic                   mem_rd_req,
   output logic [ADDR_W-1:0]      mem_rd_addr,
   input  logic                   mem_rd_valid,
   input  logic [DESC_WORD_W-1:0] mem_rd_data,
   output logic                   busy,
   output logic                   done,
   output logic                   fault,
   output logic [DESC_WORD_W-1:0] desc_base,
   output logic [LIM_W-1:0]       desc_limit,
   output logic [TYPE_W-1:0]      desc_type,
   output logic [DPL_W-1:0]       desc_dpl,
   output logic                   desc_present,
   output logic                   desc_big,
   output logic [ADDR_W-1:0]      ldt_base,
   output logic [LIM_W-1:0]       ldt_limit,
   output logic [SEL_W-1:0]       ldt_sel
);

   generate
      if (TI_BIT >= IDX_LSB) begin : g_bad_ti
         $error("table-select bit must lie below the index field");
      end
      if (IDX_LSB >= SEL_W) begin : g_bad_idx
         $error("index field must lie inside the selector");
      end
      if (ADDR_W < DESC_WORD_W) begin : g_bad_addr
         $error("address width must hold a descriptor base");
      end
      if (LIM_W < SEL_W) begin : g_bad_lim
         $error("limit width must cover the selector offset");
      end
   endgenerate

   logic                   use_local;
   logic [ADDR_W-1:0]      pick_base;
   logic [LIM_W-1:0]       pick_limit;
   logic [DESC_WORD_W-1:0] word_lo;
   desc_fields_t           dec_fields;
   logic [LIM_W-1:0]       dec_limit;
   logic                   inst_we;
   logic [SEL_W-1:0]       inst_sel;
   desc_fields_t           out_fields;

   seg_table_regs #(
      .ADDR_W (ADDR_W),
      .LIM_W  (LIM_W),
      .SEL_W  (SEL_W)
   ) u_tables (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_base   (cfg_base),
      .cfg_limit  (cfg_limit),
      .inst_we    (inst_we),
      .inst_base  (dec_fields.base),
      .inst_limit (dec_limit),
      .inst_sel   (inst_sel),
      .use_local  (use_local),
      .pick_base  (pick_base),
      .pick_limit (pick_limit),
      .loc_base   (ldt_base),
      .loc_limit  (ldt_limit),
      .loc_sel    (ldt_sel)
   );

   seg_desc_decode #(
      .GRAN_SHIFT (GRAN_SHIFT)
   ) u_decode (
      .word_lo   (word_lo),
      .word_hi   (mem_rd_data),
      .fields    (dec_fields),
      .eff_limit (dec_limit)
   );

   seg_fetch_ctrl #(
      .SEL_W   (SEL_W),
      .TI_BIT  (TI_BIT),
      .IDX_LSB (IDX_LSB),
      .ADDR_W  (ADDR_W),
      .LIM_W   (LIM_W)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_sel        (req_sel),
      .req_load_local (req_load_local),
      .pick_base      (pick_base),
      .pick_limit     (pick_limit),
      .use_local      (use_local),
      .mem_rd_req     (mem_rd_req),
      .mem_rd_addr    (mem_rd_addr),
      .mem_rd_valid   (mem_rd_valid),
      .mem_rd_data    (mem_rd_data),
      .word_lo        (word_lo),
      .dec_fields     (dec_fields),
      .dec_limit      (dec_limit),
      .inst_we        (inst_we),
      .inst_sel       (inst_sel),
      .busy           (busy),
      .done           (done),
      .fault          (fault),
      .out_fields     (out_fields),
      .out_limit      (desc_limit)
   );

   assign desc_base    = out_fields.base;
   assign desc_type    = out_fields.kind;
   assign desc_dpl     = out_fields.dpl;
   assign desc_present = out_fields.present;
   assign desc_big     = out_fields.big;

endmodule

// File: rtl/seg_desc_fetch_chk.sv
module seg_desc_fetch_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LIM_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              fault,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic [31:0]       desc_base,
   input logic [LIM_W-1:0]  desc_limit
);

   logic [1:0]        rd_cnt;
   logic [ADDR_W-1:0] prev_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_cnt    <= '0;
         prev_addr <= '0;
      end else begin
         if (!busy) begin
            rd_cnt <= '0;
         end else if (mem_rd_req) begin
            rd_cnt <= rd_cnt + 2'd1;
         end
         if (mem_rd_req) begin
            prev_addr <= mem_rd_addr;
         end
      end
   end

   a_r8_done_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !mem_rd_req);

   a_r3_read_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |-> busy);

   a_r3_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && rd_cnt == 2'd1) |-> (mem_rd_addr == prev_addr + ADDR_W'(4)));

   a_r3_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rd_cnt == 2'd2));

   a_r2_fault_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (rd_cnt == 2'd0 && !busy));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> ($stable(desc_base) && $stable(desc_limit)));

endmodule

bind seg_desc_fetch seg_desc_fetch_chk #(
   .ADDR_W (ADDR_W),
   .LIM_W  (LIM_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .busy        (busy),
   .done        (done),
   .fault       (fault),
   .mem_rd_req  (mem_rd_req),
   .mem_rd_addr (mem_rd_addr),
   .desc_base   (desc_base),
   .desc_limit  (desc_limit)
);

// File: tb/seg_desc_fetch_test.sv
`timescale 1ns/1ps
module seg_desc_fetch_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_sel = '0;
   logic        req_load_local = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [31:0] cfg_limit = '0;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        busy, done, fault;
   logic [31:0] desc_base, desc_limit;
   logic [4:0]  desc_type;
   logic [1:0]  desc_dpl;
   logic        desc_present, desc_big;
   logic [31:0] ldt_base, ldt_limit;
   logic [15:0] ldt_sel;

   always #2 clk = ~clk;

   seg_desc_fetch uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_load_local(req_load_local), .cfg_we(cfg_we), .cfg_base(cfg_base),
      .cfg_limit(cfg_limit), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .busy(busy),
      .done(done), .fault(fault), .desc_base(desc_base), .desc_limit(desc_limit),
      .desc_type(desc_type), .desc_dpl(desc_dpl), .desc_present(desc_present),
      .desc_big(desc_big), .ldt_base(ldt_base), .ldt_limit(ldt_limit), .ldt_sel(ldt_sel)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] gdt_b = '0, gdt_l = '0, ldt_b = '0, ldt_l = '0;
   logic [15:0] ldt_s = '0;
   logic [31:0] exp_a0 = '0;
   int          rd_idx = 0;
   logic [31:0] ov_a [4];
   logic [31:0] ov_d [4];
   int          ov_n = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mw(input logic [31:0] a);
      logic [31:0] w;
      for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) return ov_d[i];
      w = a * 32'h9E3779B1;
      w = w ^ (w >> 15);
      w = w * 32'h85EBCA6B;
      w = w ^ (w >> 13);
      return w;
   endfunction

   function automatic logic [31:0] ex_base(input logic [31:0] lo, input logic [31:0] hi);
      return {hi[31:24], hi[7:0], lo[31:16]};
   endfunction

   function automatic logic [31:0] ex_limit(input logic [31:0] lo, input logic [31:0] hi);
      logic [19:0] raw;
      raw = {hi[19:16], lo[15:0]};
      return hi[23] ? {raw, 12'hFFF} : {12'h000, raw};
   endfunction

   // memory responder: one read at a time, 1..4 cycle latency
   initial begin
      int pend = 0;
      logic [31:0] paddr = '0;
      forever begin
         @(negedge clk);
         mem_rd_valid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = mw(paddr);
            end
         end
         if (mem_rd_req) begin
            chk(pend == 0, "R3 overlapping read", 64'(pend), 64'd0);
            chk(mem_rd_addr == exp_a0 + 32'(4 * rd_idx), "R1 R3 read address",
                64'(mem_rd_addr), 64'(exp_a0 + 32'(4 * rd_idx)));
            rd_idx++;
            paddr = mem_rd_addr;
            pend  = $urandom_range(1, 4);
         end
      end
   end

   task automatic set_gdt(input logic [31:0] b, input logic [31:0] l);
      @(negedge clk);
      cfg_we = 1'b1; cfg_base = b; cfg_limit = l;
      @(negedge clk);
      cfg_we = 1'b0;
      gdt_b = b; gdt_l = l;
   endtask

   task automatic run_req(input logic [15:0] sel, input bit op, input bit cfg_now,
                          input logic [31:0] cb, input logic [31:0] cl, input bit poke);
      bit          ul, ef;
      logic [31:0] b, l, off, lo, hi, held_b, held_l;
      int          cnt;
      ul  = sel[2] && !op;
      b   = ul ? ldt_b : gdt_b;
      l   = ul ? ldt_l : gdt_l;
      off = {16'h0, sel[15:3], 3'b000};
      ef  = off >= l;
      exp_a0 = b + off;
      rd_idx = 0;
      @(negedge clk);
      req_valid = 1'b1; req_sel = sel; req_load_local = op;
      if (cfg_now) begin cfg_we = 1'b1; cfg_base = cb; cfg_limit = cl; end
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      if (cfg_now) begin gdt_b = cb; gdt_l = cl; end
      if (ef) begin
         chk(fault === 1'b1, "R2 R11 fault expected", 64'(fault), 64'd1);
         chk(done === 1'b0 && busy === 1'b0, "R8 no done/busy on fault", 64'({done, busy}), 64'd0);
         chk(desc_base == 0 && desc_limit == 0, "R10 cleared on accept", 64'(desc_base), 64'd0);
         @(negedge clk);
         chk(fault === 1'b0, "R8 fault pulse", 64'(fault), 64'd0);
         chk(rd_idx == 0, "R2 no read on fault", 64'(rd_idx), 64'd0);
         return;
      end
      chk(busy === 1'b1 && fault === 1'b0, "R8 R11 busy after accept", 64'({busy, fault}), 64'b10);
      chk(desc_base == 0 && desc_limit == 0 && desc_type == 0, "R10 cleared on accept",
          64'(desc_base), 64'd0);
      if (poke) begin
         req_valid = 1'b1; req_sel = ~sel; req_load_local = ~op;
         @(negedge clk);
         req_valid = 1'b0;
      end
      cnt = 0;
      while (done !== 1'b1 && cnt < 100) begin
         if (fault === 1'b1) chk(1'b0, "R8 stray fault", 64'd1, 64'd0);
         @(negedge clk);
         cnt++;
      end
      lo = mw(exp_a0);
      hi = mw(exp_a0 + 32'd4);
      chk(done === 1'b1 && busy === 1'b0, "R8 done with busy low", 64'({done, busy}), 64'b10);
      chk(rd_idx == 2, "R3 two reads", 64'(rd_idx), 64'd2);
      chk(desc_base == ex_base(lo, hi), "R4 base", 64'(desc_base), 64'(ex_base(lo, hi)));
      chk(desc_limit == ex_limit(lo, hi), "R5 limit", 64'(desc_limit), 64'(ex_limit(lo, hi)));
      chk({desc_type, desc_dpl, desc_present, desc_big} == {hi[12:8], hi[14:13], hi[15], hi[22]},
          "R6 attributes", 64'({desc_type, desc_dpl, desc_present, desc_big}),
          64'({hi[12:8], hi[14:13], hi[15], hi[22]}));
      if (op) begin
         ldt_b = ex_base(lo, hi);
         ldt_l = ex_limit(lo, hi);
         ldt_s = sel;
      end
      chk(ldt_base == ldt_b && ldt_limit == ldt_l && ldt_sel == ldt_s, "R7 local table regs",
          {ldt_base, ldt_limit}, {ldt_b, ldt_l});
      held_b = desc_base; held_l = desc_limit;
      @(negedge clk);
      @(negedge clk);
      chk(done === 1'b0, "R8 done pulse", 64'(done), 64'd0);
      chk(desc_base == held_b && desc_limit == held_l, "R10 hold after done",
          {desc_base, desc_limit}, {held_b, held_l});
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(busy === 0 && done === 0 && fault === 0, "R9 idle after reset", 64'({busy, done, fault}), 64'd0);
      chk(ldt_base == 0 && ldt_limit == 0 && ldt_sel == 0, "R9 local regs zero", 64'(ldt_limit), 64'd0);
      chk(desc_base == 0 && desc_limit == 0, "R9 outputs zero", 64'(desc_base), 64'd0);
      run_req(16'h0000, 1'b0, 1'b0, 0, 0, 1'b0);   // R9 global faults
      run_req(16'h0004, 1'b0, 1'b0, 0, 0, 1'b0);   // R9 local faults
      run_req(16'h0004, 1'b1, 1'b0, 0, 0, 1'b0);   // R9 load-local faults

      // directed descriptors
      ov_a[0] = 32'h0001_0020; ov_d[0] = 32'h3456_FFFF;
      ov_a[1] = 32'h0001_0024; ov_d[1] = 32'h12CF_9A78;
      ov_a[2] = 32'h0001_0010; ov_d[2] = 32'h0000_001F;
      ov_a[3] = 32'h0001_0014; ov_d[3] = 32'h0000_8220;
      ov_n = 4;
      set_gdt(32'h0001_0000, 32'h0000_0040);
      run_req(16'h0023, 1'b0, 1'b0, 0, 0, 1'b0);   // R1 masked to 0x20
      chk(desc_base == 32'h1278_3456, "R4 literal base", 64'(desc_base), 64'h12783456);
      chk(desc_limit == 32'hFFFF_FFFF, "R5 granular limit", 64'(desc_limit), 64'hFFFFFFFF);
      chk(desc_type == 5'h1A && desc_dpl == 2'd0 && desc_present && desc_big, "R6 literal attrs",
          64'({desc_type, desc_dpl, desc_present, desc_big}), 64'({5'h1A, 2'd0, 1'b1, 1'b1}));
      run_req(16'h003F, 1'b0, 1'b0, 0, 0, 1'b0);   // R1 offset 0x38 just below limit
      run_req(16'h0040, 1'b0, 1'b0, 0, 0, 1'b0);   // R2 offset equals limit
      // R7: load local from global entry 2 with bit 2 set (ignored)
      run_req(16'h0014, 1'b1, 1'b0, 0, 0, 1'b0);
      chk(ldt_base == 32'h0020_0000 && ldt_limit == 32'h1F && ldt_sel == 16'h0014,
          "R7 literal install", {ldt_base, ldt_limit}, {32'h0020_0000, 32'h1F});
      chk(desc_limit == 32'h0000_001F, "R5 byte-granular limit", 64'(desc_limit), 64'h1F);
      run_req(16'h001C, 1'b0, 1'b0, 0, 0, 1'b0);   // R1 local table address
      run_req(16'h0024, 1'b0, 1'b0, 0, 0, 1'b0);   // R2 local bound
      run_req(16'h0018, 1'b0, 1'b0, 0, 0, 1'b1);   // R8 request while busy ignored

      // R11: config write on the acceptance edge
      set_gdt(32'h0003_0000, 32'h0000_0000);
      run_req(16'h0008, 1'b0, 1'b1, 32'h0003_0000, 32'h0000_1000, 1'b0);
      run_req(16'h0008, 1'b0, 1'b0, 0, 0, 1'b0);
      run_req(16'h0010, 1'b0, 1'b1, 32'h0005_0000, 32'h0000_0000, 1'b0);
      run_req(16'h0010, 1'b0, 1'b0, 0, 0, 1'b0);
      set_gdt(32'h0004_0000, 32'h0000_0800);
      run_req(16'h0030, 1'b0, 1'b1, 32'h0009_0000, 32'h0000_0800, 1'b0);
      run_req(16'h0030, 1'b0, 1'b0, 0, 0, 1'b0);

      // constrained random
      for (int it = 0; it < 180; it++) begin
         logic [15:0] s;
         logic [31:0] nb, nl;
         bit          op, cn, pk;
         if (it % 25 == 0) begin
            nb = $urandom;
            nl = ($urandom_range(0, 3) == 0) ? 32'h0001_0000 : 32'($urandom_range(0, 16'h3000));
            set_gdt(nb, nl);
         end
         s  = 16'($urandom_range(0, 16'h3FFF));
         op = ($urandom_range(0, 7) == 0);
         cn = ($urandom_range(0, 9) == 0);
         pk = ($urandom_range(0, 4) == 0);
         nb = $urandom;
         nl = 32'($urandom_range(0, 16'h4000));
         run_req(s, op, cn, nb, nl, pk);
      end
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule